// File: doc/BRIEF.md
# Four-Channel Real-Time Tick Prescaler

This block turns a nominal 32 kHz reference clock into four tick streams for real-time timekeeping. One shared 15-bit binary counter runs on the reference clock. Each of the four channels watches one power-of-two tap of that counter. A channel picks its tap from its own staggered group of four consecutive ratios, and the four groups together cover every ratio from divide-by-1 to divide-by-32768. At 32 kHz this gives rates from 32 kHz down to 1 Hz.

Software configures the block through a single 16-bit control word. The word has a write strobe and a read-back bus. It holds one global run bit, one wakeup-enable bit per channel, and a 2-bit ratio select per channel. When a channel's wakeup enable is set, each tick on that channel also raises the shared wakeup request. The wakeup request is registered. All pins are plain level or strobe signals. There is no streaming data path, so the block has no valid/ready handshake.

Top module: `tick_prescaler`

## Requirements
- R1: While reset is asserted and right after it is released, the control word reads 0x0000, every tick output is 0 and the wakeup output is 0.
- R2: A write stores the written word into the control word, masked by 0x8FFF. The stored value is readable in the cycle after the write strobe edge. Bit 15 is the run bit, bits 11..8 are the wakeup enables of channels 3..0, and bits [2c+1:2c] are the select of channel c.
- R3: Bits 14..12 always read 0, and writes to them have no effect.
- R4: While the run bit is 0, the counter is held at zero. No tick and no wakeup occurs, whatever the select and wakeup-enable settings.
- R5: Channel 3 (select in bits 7:6) divides by 1, 2, 4 or 8 for select codes 0, 1, 2 and 3.
- R6: Channel 2 (select in bits 5:4) divides by 16, 32, 64 or 128 for codes 0 to 3.
- R7: Channel 1 (select in bits 3:2) divides by 256, 512, 1024 or 2048 for codes 0 to 3.
- R8: Channel 0 (select in bits 1:0) divides by 4096, 8192, 16384 or 32768 for codes 0 to 3.
- R9: For a ratio of 2^e, a channel's tick is a single-cycle pulse. It is high exactly when the low e bits of the counter are all ones. The counter reads 0 in the first cycle after the run bit is set, so the first tick comes 2^e−1 cycles later. A ratio of 1 ticks on every running cycle. The counter wraps from 32767 to 0.
- R10: The wakeup output is high in the cycle after any channel ticks while that channel's wakeup enable is 1. Otherwise it is low.
- R11: A select change does not reset the counter. The channel follows its new tap from the next cycle on.
- R12: Clearing the run bit and setting it again restarts counting from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (nominal 32 kHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Value to write into the control word |
| rd_data | output | 16 | Current control word |
| tick_o | output | 4 | Per-channel tick pulses, bit c for channel c |
| wake_o | output | 1 | Registered wakeup request |

## Verification
On every cycle, the assertions check the following:
- a written word is read back through the write mask;
- a stopped counter stays at zero and a running one advances by exactly one;
- no tick appears while stopped;
- a tick at a ratio above 1 never lasts two cycles;
- every wakeup is preceded by a tick.

The actual ratio each select code produces, the placement of ticks relative to the run edge, the wrap at 32768, and the behaviour after a live select change or a stop-restart can only be shown by the bench's sweeps. In those sweeps every output is compared, cycle by cycle, against an arithmetic model of the counter.

// File: rtl/tick_presc_pkg.sv
package tick_presc_pkg;

  // Exponent of the lowest ratio in a channel's group; the highest channel is fastest.
  function automatic int unsigned tap_base(int unsigned ch, int unsigned num_ch,
                                           int unsigned group);
    return (num_ch - 1 - ch) * group;
  endfunction

endpackage

// File: rtl/tp_ctrl_reg.sv
module tp_ctrl_reg #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned REG_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [REG_W-1:0]          wr_data,
  output logic [REG_W-1:0]          rd_data,
  output logic                      run_en,
  output logic [NUM_CH-1:0]         wake_en,
  output logic [NUM_CH*SEL_W-1:0]   sel_all
);
  localparam int unsigned SEL_TOT = NUM_CH * SEL_W;
  localparam int unsigned WEN_LO  = SEL_TOT;
  localparam int unsigned EN_BIT  = REG_W - 1;
  localparam logic [REG_W-1:0] WMASK =
    (REG_W'(1) << EN_BIT) | ((REG_W'(1) << (WEN_LO + NUM_CH)) - REG_W'(1));

  logic unused_rsvd;
  assign unused_rsvd = ^(wr_data & ~WMASK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_en  <= 1'b0;
      wake_en <= '0;
      sel_all <= '0;
    end else if (wr_en) begin
      run_en  <= wr_data[EN_BIT];
      wake_en <= wr_data[WEN_LO +: NUM_CH];
      sel_all <= wr_data[SEL_TOT-1:0];
    end
  end

  always_comb begin
    rd_data                     = '0;
    rd_data[SEL_TOT-1:0]        = sel_all;
    rd_data[WEN_LO +: NUM_CH]   = wake_en;
    rd_data[EN_BIT]             = run_en;
  end

  // R2, R3: written word is visible one edge later, reserved bits stripped
  assert_write_back_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == ($past(wr_data) & WMASK));

endmodule

// File: rtl/tp_divider.sv
module tp_divider #(
  parameter int unsigned DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  output logic [DIV_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (run_en) cnt <= cnt + DIV_W'(1);
    else             cnt <= '0;
  end

  assert_hold_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> cnt == '0);

  assert_step_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> cnt == $past(cnt) + DIV_W'(1));

endmodule

// File: rtl/tp_tap_sel.sv
module tp_tap_sel #(
  parameter int unsigned DIV_W = 15,
  parameter int unsigned SEL_W = 2,
  parameter int unsigned BASE  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [DIV_W-1:0] cnt,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned EXP_W = $clog2(DIV_W + 1) + 1;

  logic [EXP_W-1:0] tap_exp;
  logic [DIV_W:0]   span;
  logic [DIV_W-1:0] low_mask;
  logic             unused_span_top;

  assign tap_exp         = EXP_W'(BASE) + EXP_W'(sel);
  assign span            = ((DIV_W+1)'(1) << tap_exp) - (DIV_W+1)'(1);
  assign low_mask        = span[DIV_W-1:0];
  assign unused_span_top = span[DIV_W];
  assign tick            = run_en && ((cnt & low_mask) == low_mask);

  // R9: a tick on a ratio above 1 is a single-cycle pulse
  assert_tick_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && tap_exp != '0) |=> (!tick || tap_exp == '0));

endmodule

// File: rtl/tp_wake_gen.sv
module tp_wake_gen #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] tick,
  input  logic [NUM_CH-1:0] wake_en,
  output logic              wake
);
  always_ff @(posedge clk) begin
    if (!rst_n) wake <= 1'b0;
    else        wake <= |(tick & wake_en);
  end
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic [NUM_CH-1:0] tick_o,
  output logic              wake_o
);
  import tick_presc_pkg::*;

  localparam int unsigned GROUP = 1 << SEL_W;
  localparam int unsigned DIV_W = NUM_CH * GROUP - 1;

  logic                    run_en;
  logic [NUM_CH-1:0]       wake_en;
  logic [NUM_CH*SEL_W-1:0] sel_all;
  logic [DIV_W-1:0]        cnt;

  tp_ctrl_reg #(.NUM_CH(NUM_CH), .SEL_W(SEL_W), .REG_W(REG_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .run_en(run_en), .wake_en(wake_en), .sel_all(sel_all));

  tp_divider #(.DIV_W(DIV_W)) div_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cnt(cnt));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    tp_tap_sel #(
      .DIV_W(DIV_W), .SEL_W(SEL_W), .BASE(tap_base(ch, NUM_CH, GROUP))
    ) tap_i (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .cnt(cnt),
      .sel(sel_all[ch*SEL_W +: SEL_W]), .tick(tick_o[ch]));
  end

  tp_wake_gen #(.NUM_CH(NUM_CH)) wake_i (
    .clk(clk), .rst_n(rst_n), .tick(tick_o), .wake_en(wake_en), .wake(wake_o));

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> tick_o == '0);

  assert_wake_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> $past(|tick_o));

endmodule

// File: tb/tick_prescaler_tb_top.sv
module tick_prescaler_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = 16'h0;
  logic [15:0] rd_data;
  logic [3:0]  tick_o;
  logic        wake_o;

  always #2 clk = ~clk;

  tick_prescaler dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .tick_o(tick_o), .wake_o(wake_o));

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  bit          checking = 1'b0;
  string       phase = "boot";

  logic [15:0] m_ctrl;
  logic [14:0] m_cnt;
  logic        m_wake;
  logic [3:0]  m_ticks;

  function automatic logic [3:0] model_ticks(logic [15:0] ctrl, logic [14:0] cnt);
    logic [3:0]  t;
    int          e;
    logic [14:0] m;
    for (int c = 0; c < 4; c++) begin
      e    = (3 - c) * 4 + int'(ctrl[c*2 +: 2]);
      m    = 15'((32'd1 << e) - 1);
      t[c] = ctrl[15] && ((cnt & m) == m);
    end
    return t;
  endfunction

  function automatic string chan_req(int c);
    case (c)
      0: return "R8";
      1: return "R7";
      2: return "R6";
      default: return "R5";
    endcase
  endfunction

  assign m_ticks = model_ticks(m_ctrl, m_cnt);

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl <= 16'h0;
      m_cnt  <= 15'd0;
      m_wake <= 1'b0;
    end else begin
      m_wake <= |(m_ticks & m_ctrl[11:8]);
      m_cnt  <= m_ctrl[15] ? m_cnt + 15'd1 : 15'd0;
      if (wr_en) m_ctrl <= wr_data & 16'h8FFF;
    end
  end

  task automatic check(bit ok, string req, string what, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s [%s] got %h exp %h", req, what, phase, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      for (int c = 0; c < 4; c++)
        check(tick_o[c] == m_ticks[c], chan_req(c), $sformatf("tick ch%0d R9", c),
              16'(tick_o[c]), 16'(m_ticks[c]));
      check(wake_o == m_wake, "R10", "wake", 16'(wake_o), 16'(m_wake));
      check(rd_data == m_ctrl, "R2", "readback", rd_data, m_ctrl);
    end
  end

  task automatic write_ctrl(logic [15:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    checking = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired [%s] got %h exp %h", phase, 16'h0, 16'h1);
    finish_run();
  end

  initial begin
    logic [3:0] wen;
    idle(3);
    phase = "R1 in reset";
    check(rd_data == 16'h0, "R1", "ctrl", rd_data, 16'h0);
    check(tick_o == 4'h0, "R1", "ticks", 16'(tick_o), 16'h0);
    check(wake_o == 1'b0, "R1", "wake", 16'(wake_o), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    phase = "R1 released";
    check(rd_data == 16'h0, "R1", "ctrl", rd_data, 16'h0);
    check(tick_o == 4'h0, "R1", "ticks", 16'(tick_o), 16'h0);
    checking = 1'b1;

    phase = "R3 reserved";
    write_ctrl(16'hF000);
    check(rd_data == 16'h8000, "R3", "reserved masked", rd_data, 16'h8000);
    idle(5);
    write_ctrl(16'h7000);
    check(rd_data == 16'h0000, "R3", "reserved only", rd_data, 16'h0000);
    write_ctrl(16'hFFFF);
    check(rd_data == 16'h8FFF, "R3", "all ones", rd_data, 16'h8FFF);
    idle(20);

    phase = "R4 stopped";
    write_ctrl(16'h0F55);
    idle(64);
    check(tick_o == 4'h0, "R4", "ticks stopped", 16'(tick_o), 16'h0);
    check(wake_o == 1'b0, "R4", "wake stopped", 16'(wake_o), 16'h0);

    for (int s = 0; s < 4; s++) begin
      phase = $sformatf("ratio sweep sel %0d", s);
      case (s)
        0: wen = 4'hF;
        1: wen = 4'h5;
        2: wen = 4'hA;
        default: wen = 4'h1;
      endcase
      write_ctrl(16'h0000);
      write_ctrl(16'h8000 | (16'(wen) << 8) | 16'({4{2'(s)}}));
      idle((1 << (12 + s)) + 40);
    end

    phase = "R11 reselect";
    write_ctrl(16'h0000);
    write_ctrl(16'h8F00);
    idle(37);
    write_ctrl(16'h8F36);
    idle(2500);
    write_ctrl(16'h8F9C);
    idle(2500);

    phase = "R12 restart";
    write_ctrl(16'h0F1B);
    idle(17);
    write_ctrl(16'h8F1B);
    idle(600);

    finish_run();
  end
endmodule